// File: doc/BRIEF.md
# Machine-Mode Trap CSR Unit

This block keeps the machine-level control and status registers that a processor core consults when it enters or leaves a trap. It also executes the CSR access instructions against those registers. The core presents one instruction boundary per cycle on `instValid`. With it come that instruction's program counter, any CSR access, any synchronous exception and any trap-return request. In the same cycle the unit returns the old CSR value and reports whether the flow of control must change. When it must, it also supplies the next program counter.

Two interrupt lines, one for the timer and one for software, are compared against a global enable and against per-source enables. A pending, enabled interrupt pre-empts the instruction at the boundary. That instruction is not executed: its program counter is saved so that the return sequence resumes it. Register updates commit at the clock edge, so a CSR write made at one boundary governs the interrupt decision at the next.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset every implemented CSR reads zero while both interrupt lines are low, and no redirect is issued. The addresses are status 0x300, enable 0x304, vector base 0x305, scratch 0x340, saved PC 0x341, cause 0x342, trap value 0x343 and pending 0x344. Any other address reads zero.
- R2: A read-write access (csrOp=01) returns the old CSR value on `csrRdata` in the same cycle. It writes the source operand at the clock edge, so the scratch register can be swapped with a source value.
- R3: A set access (csrOp=10) ORs the source into the CSR, and a clear access (csrOp=11) clears the source's one bits. Either one with a zero source leaves the CSR unchanged.
- R4: With `csrUseImm` high the source operand is the 5-bit `csrZimm`, zero-extended. Otherwise it is `csrRs1`.
- R5: A synchronous exception (`excValid`) raises `trapTaken` and `redirect`. It sets `nextPc` to the vector base with bits [1:0] zero. At the clock edge it stores the instruction PC into the saved-PC register, `excCause` into the cause register and `excTval` into the trap-value register.
- R6: On trap entry, status bit 3 (global enable) is copied into status bit 7 (previous enable), and bit 3 is then cleared.
- R7: A trap return (`mretValid`) raises `redirect` with `nextPc` equal to the saved PC. It restores status bit 3 from bit 7 and sets bit 7 to one. `trapTaken` stays low.
- R8: An interrupt is taken only when status bit 3 is set, the line is high and its enable bit is set (enable bit 7 for the timer, bit 3 for software). The timer gives cause 0x80000007, software gives cause 0x80000003, and the trap value is written as zero.
- R9: When both enabled interrupts are pending, the software interrupt is taken.
- R10: Pending-register bit 7 follows `timerIrq` and bit 3 follows `softIrq`. Writes to the pending register have no effect.
- R11: Vector-base bits [1:0] always read zero (direct mode only).
- R12: A CSR write at one boundary is visible to the interrupt check at the next boundary. An interrupt taken at a boundary suppresses that instruction's CSR access, exception and return. Priority is interrupt, then exception, then trap return, then CSR access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction boundary is presented this cycle |
| instPc | input | 32 | Program counter of the presented instruction |
| csrOp | input | 2 | 00 none, 01 read-write, 10 set bits, 11 clear bits |
| csrUseImm | input | 1 | Use the 5-bit immediate as the source operand |
| csrAddr | input | 12 | CSR address |
| csrRs1 | input | 32 | Register source operand |
| csrZimm | input | 5 | Immediate source operand |
| csrRdata | output | 32 | Old value of the addressed CSR |
| excValid | input | 1 | The instruction raises a synchronous exception |
| excCause | input | 32 | Cause code of that exception |
| excTval | input | 32 | Extra information for that exception |
| mretValid | input | 1 | The instruction is a trap return |
| timerIrq | input | 1 | Timer interrupt line |
| softIrq | input | 1 | Software interrupt line |
| trapTaken | output | 1 | A trap is entered this cycle |
| redirect | output | 1 | The core must fetch from nextPc |
| nextPc | output | 32 | Redirect target |

## Verification
On every cycle, the assertions check several things. They check that the saved PC captures the trapping instruction's PC. They check that the status enable bits shift on trap entry and return, and that a zero-mask set or clear leaves the scratch register alone. They also check that at most one of entry, return and CSR write happens in a cycle, and that an interrupt never fires with the global enable low or ahead of a pending software interrupt. Other behaviours depend on whole sequences, and only the bench's scenarios show them. These include the exact cause and trap-value contents and the swap semantics. They also include the one-boundary latency between enabling an interrupt and taking it, the suppression of the pre-empted instruction's CSR write, the read-only pending bits and the alignment of the vector base.

// File: rtl/trapcsr_pkg.sv
package trapcsr_pkg;
  parameter int XLEN   = 32;
  parameter int ADDR_W = 12;
  parameter int ZIMM_W = 5;

  localparam int GIE_BIT   = 3;
  localparam int PGIE_BIT  = 7;
  localparam int TIMER_BIT = 7;
  localparam int SOFT_BIT  = 3;

  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 12'h304;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 12'h305;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] A_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] A_TVAL    = 12'h343;
  localparam logic [ADDR_W-1:0] A_PENDING = 12'h344;

  localparam logic [XLEN-1:0] CAUSE_TIMER = {1'b1, (XLEN-1)'(TIMER_BIT)};
  localparam logic [XLEN-1:0] CAUSE_SOFT  = {1'b1, (XLEN-1)'(SOFT_BIT)};

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RW   = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  typedef struct packed {
    logic            trapEnter;
    logic            trapReturn;
    logic            csrWe;
    logic            irqTrap;
    logic [XLEN-1:0] cause;
  } ctrl_strobe_t;
endpackage

// File: rtl/trapcsr_ctrl.sv
module trapcsr_ctrl
  import trapcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  csr_op_e         csrOp,
  input  logic            excValid,
  input  logic [XLEN-1:0] excCause,
  input  logic            mretValid,
  input  logic            timerIrq,
  input  logic            softIrq,
  input  logic            gIe,
  input  logic            timerEn,
  input  logic            softEn,
  input  logic            srcZero,
  output ctrl_strobe_t    strobe
);
  logic softHit, timerHit, irqGo;

  assign softHit  = softIrq & softEn;
  assign timerHit = timerIrq & timerEn;
  assign irqGo    = instValid & gIe & (softHit | timerHit);

  always_comb begin
    strobe = '0;
    if (irqGo) begin
      strobe.trapEnter = 1'b1;
      strobe.irqTrap   = 1'b1;
      strobe.cause     = softHit ? CAUSE_SOFT : CAUSE_TIMER;
    end else if (instValid && excValid) begin
      strobe.trapEnter = 1'b1;
      strobe.cause     = excCause;
    end else if (instValid && mretValid) begin
      strobe.trapReturn = 1'b1;
    end else if (instValid && csrOp != OP_NONE) begin
      strobe.csrWe = (csrOp == OP_RW) || !srcZero;
    end
  end

  // R8: no interrupt trap while the global enable is clear
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.irqTrap |-> gIe);

  // R9: software wins over timer when both are pending and enabled
  assert_soft_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && gIe && softIrq && softEn && timerIrq && timerEn)
      |-> (strobe.irqTrap && strobe.cause == CAUSE_SOFT));

  // R12: a boundary does one of entry, return or CSR write, never two
  assert_single_action_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.trapEnter, strobe.trapReturn, strobe.csrWe}));
endmodule

// File: rtl/trapcsr_dp.sv
module trapcsr_dp
  import trapcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [XLEN-1:0]   instPc,
  input  csr_op_e           csrOp,
  input  logic              csrUseImm,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrRs1,
  input  logic [ZIMM_W-1:0] csrZimm,
  input  logic [XLEN-1:0]   excTval,
  input  logic              timerIrq,
  input  logic              softIrq,
  output logic [XLEN-1:0]   csrRdata,
  output logic              gIe,
  output logic              timerEn,
  output logic              softEn,
  output logic              srcZero,
  output logic              redirect,
  output logic [XLEN-1:0]   nextPc
);
  localparam int VEC_W = XLEN - 2;

  logic            prevIe;
  logic [VEC_W-1:0] vecBase;
  logic [XLEN-1:0] epcQ, causeQ, tvalQ, scratchQ;
  logic [XLEN-1:0] srcVal, newVal, statusVal, enableVal, pendingVal;

  assign srcVal  = csrUseImm ? XLEN'(csrZimm) : csrRs1;
  assign srcZero = (srcVal == '0);

  always_comb begin
    statusVal = '0;
    statusVal[GIE_BIT]  = gIe;
    statusVal[PGIE_BIT] = prevIe;
    enableVal = '0;
    enableVal[TIMER_BIT] = timerEn;
    enableVal[SOFT_BIT]  = softEn;
    pendingVal = '0;
    pendingVal[TIMER_BIT] = timerIrq;
    pendingVal[SOFT_BIT]  = softIrq;
  end

  always_comb begin
    unique case (csrAddr)
      A_STATUS:  csrRdata = statusVal;
      A_ENABLE:  csrRdata = enableVal;
      A_VECTOR:  csrRdata = {vecBase, 2'b00};
      A_SCRATCH: csrRdata = scratchQ;
      A_EPC:     csrRdata = epcQ;
      A_CAUSE:   csrRdata = causeQ;
      A_TVAL:    csrRdata = tvalQ;
      A_PENDING: csrRdata = pendingVal;
      default:   csrRdata = '0;
    endcase
  end

  always_comb begin
    unique case (csrOp)
      OP_SET:  newVal = csrRdata | srcVal;
      OP_CLR:  newVal = csrRdata & ~srcVal;
      default: newVal = srcVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gIe      <= 1'b0;
      prevIe   <= 1'b0;
      timerEn  <= 1'b0;
      softEn   <= 1'b0;
      vecBase  <= '0;
      epcQ     <= '0;
      causeQ   <= '0;
      tvalQ    <= '0;
      scratchQ <= '0;
    end else if (strobe.trapEnter) begin
      epcQ   <= instPc;
      causeQ <= strobe.cause;
      tvalQ  <= strobe.irqTrap ? '0 : excTval;
      prevIe <= gIe;
      gIe    <= 1'b0;
    end else if (strobe.trapReturn) begin
      gIe    <= prevIe;
      prevIe <= 1'b1;
    end else if (strobe.csrWe) begin
      unique case (csrAddr)
        A_STATUS: begin
          gIe    <= newVal[GIE_BIT];
          prevIe <= newVal[PGIE_BIT];
        end
        A_ENABLE: begin
          timerEn <= newVal[TIMER_BIT];
          softEn  <= newVal[SOFT_BIT];
        end
        A_VECTOR:  vecBase  <= newVal[XLEN-1:2];
        A_SCRATCH: scratchQ <= newVal;
        A_EPC:     epcQ     <= newVal;
        A_CAUSE:   causeQ   <= newVal;
        A_TVAL:    tvalQ    <= newVal;
        default: ;
      endcase
    end
  end

  assign redirect = strobe.trapEnter | strobe.trapReturn;
  assign nextPc   = strobe.trapReturn ? epcQ : {vecBase, 2'b00};

  // R5: the trapping instruction's PC lands in the saved-PC register
  assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapEnter |=> (epcQ == $past(instPc)));

  // R6: enable stack pushes on entry
  assert_ie_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapEnter |=> (!gIe && prevIe == $past(gIe)));

  // R7: enable stack pops on return
  assert_ie_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapReturn |=> (prevIe && gIe == $past(prevIe)));

  // R3: zero-mask set or clear of scratch leaves it intact
  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((csrOp == OP_SET || csrOp == OP_CLR) && srcZero
      && csrAddr == A_SCRATCH && !strobe.trapEnter) |=> $stable(scratchQ));
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import trapcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [XLEN-1:0]   instPc,
  input  logic [1:0]        csrOp,
  input  logic              csrUseImm,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrRs1,
  input  logic [ZIMM_W-1:0] csrZimm,
  output logic [XLEN-1:0]   csrRdata,
  input  logic              excValid,
  input  logic [XLEN-1:0]   excCause,
  input  logic [XLEN-1:0]   excTval,
  input  logic              mretValid,
  input  logic              timerIrq,
  input  logic              softIrq,
  output logic              trapTaken,
  output logic              redirect,
  output logic [XLEN-1:0]   nextPc
);
  ctrl_strobe_t strobe;
  csr_op_e      opSel;
  logic         gIe, timerEn, softEn, srcZero;

  assign opSel     = csr_op_e'(csrOp);
  assign trapTaken = strobe.trapEnter;

  trapcsr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .csrOp(opSel),
    .excValid(excValid), .excCause(excCause), .mretValid(mretValid),
    .timerIrq(timerIrq), .softIrq(softIrq), .gIe(gIe),
    .timerEn(timerEn), .softEn(softEn), .srcZero(srcZero), .strobe(strobe)
  );

  trapcsr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instPc(instPc),
    .csrOp(opSel), .csrUseImm(csrUseImm), .csrAddr(csrAddr),
    .csrRs1(csrRs1), .csrZimm(csrZimm), .excTval(excTval),
    .timerIrq(timerIrq), .softIrq(softIrq), .csrRdata(csrRdata),
    .gIe(gIe), .timerEn(timerEn), .softEn(softEn), .srcZero(srcZero),
    .redirect(redirect), .nextPc(nextPc)
  );
endmodule

// File: tb/mtrap_csr_unit_tb.sv
module mtrap_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instValid, csrUseImm, excValid, mretValid, timerIrq, softIrq;
  logic [31:0] instPc, csrRs1, excCause, excTval;
  logic [1:0]  csrOp;
  logic [11:0] csrAddr;
  logic [4:0]  csrZimm;
  logic [31:0] csrRdata, nextPc;
  logic        trapTaken, redirect;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  logic [31:0] gRd, gNpc;
  logic        gTaken, gRedir;

  always #5 clk = ~clk;

  mtrap_csr_unit u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instPc(instPc),
    .csrOp(csrOp), .csrUseImm(csrUseImm), .csrAddr(csrAddr),
    .csrRs1(csrRs1), .csrZimm(csrZimm), .csrRdata(csrRdata),
    .excValid(excValid), .excCause(excCause), .excTval(excTval),
    .mretValid(mretValid), .timerIrq(timerIrq), .softIrq(softIrq),
    .trapTaken(trapTaken), .redirect(redirect), .nextPc(nextPc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instValid = 0; instPc = 0; csrOp = 0; csrUseImm = 0; csrAddr = 0;
    csrRs1 = 0; csrZimm = 0; excValid = 0; excCause = 0; excTval = 0;
    mretValid = 0;
  endtask

  task automatic boundary(input logic [31:0] pc, input logic [1:0] op,
                          input logic useImm, input logic [11:0] a,
                          input logic [31:0] v, input logic exc,
                          input logic [31:0] cause, input logic [31:0] tval,
                          input logic mret);
    @(negedge clk);
    instValid = 1; instPc = pc; csrOp = op; csrUseImm = useImm; csrAddr = a;
    csrRs1 = v; csrZimm = v[4:0]; excValid = exc; excCause = cause;
    excTval = tval; mretValid = mret;
    #1;
    gRd = csrRdata; gTaken = trapTaken; gRedir = redirect; gNpc = nextPc;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic csrOpReg(input logic [1:0] op, input logic [11:0] a, input logic [31:0] v);
    boundary(32'h100, op, 0, a, v, 0, 0, 0, 0);
  endtask

  task automatic csrOpImm(input logic [1:0] op, input logic [11:0] a, input logic [4:0] v);
    boundary(32'h100, op, 1, a, {27'd0, v}, 0, 0, 0, 0);
  endtask

  task automatic readCsr(input logic [11:0] a, output logic [31:0] val);
    csrOpImm(2'b10, a, 5'd0);
    val = gRd;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [11:0] addrs [9];
    addrs = '{12'h300, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343, 12'h344, 12'h7C0};
    foreach (addrs[i]) begin
      readCsr(addrs[i], v);
      check("R1 reset value", v, 0);
      check("R1 no redirect", {31'd0, gRedir}, 0);
    end
  endtask

  task automatic t_swap();
    logic [31:0] v;
    csrOpReg(2'b01, 12'h340, 32'hA5A5_0001);
    check("R2 old value", gRd, 0);
    csrOpReg(2'b01, 12'h340, 32'h0000_1234);
    check("R2 swap returns old", gRd, 32'hA5A5_0001);
    readCsr(12'h340, v);
    check("R2 swap wrote new", v, 32'h0000_1234);
  endtask

  task automatic t_setClear();
    logic [31:0] v;
    csrOpImm(2'b10, 12'h340, 5'h1F);
    readCsr(12'h340, v);
    check("R4 set with immediate", v, 32'h0000_123F);
    csrOpReg(2'b11, 12'h340, 32'h0000_1200);
    readCsr(12'h340, v);
    check("R3 clear with register", v, 32'h0000_003F);
    csrOpReg(2'b10, 12'h340, 32'h0);
    readCsr(12'h340, v);
    check("R3 zero-mask set", v, 32'h0000_003F);
    csrOpImm(2'b11, 12'h340, 5'd0);
    readCsr(12'h340, v);
    check("R3 zero-mask clear", v, 32'h0000_003F);
    boundary(32'h100, 2'b01, 1, 12'h340, 32'hFFFF_FFE5, 0, 0, 0, 0);
    readCsr(12'h340, v);
    check("R4 immediate zero-extended", v, 32'h0000_0005);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    csrOpReg(2'b01, 12'h305, 32'h8000_0103);
    readCsr(12'h305, v);
    check("R11 vector low bits", v, 32'h8000_0100);
  endtask

  task automatic t_exception();
    logic [31:0] v;
    csrOpImm(2'b10, 12'h300, 5'd8);
    boundary(32'h0000_0400, 2'b00, 0, 0, 0, 1, 32'd2, 32'hDEAD_0000, 0);
    check("R5 trapTaken", {31'd0, gTaken}, 1);
    check("R5 redirect", {31'd0, gRedir}, 1);
    check("R5 nextPc is vector", gNpc, 32'h8000_0100);
    readCsr(12'h341, v); check("R5 saved pc", v, 32'h400);
    readCsr(12'h342, v); check("R5 cause", v, 32'd2);
    readCsr(12'h343, v); check("R5 trap value", v, 32'hDEAD_0000);
    readCsr(12'h300, v); check("R6 status after entry", v, 32'h80);
  endtask

  task automatic t_return();
    logic [31:0] v;
    boundary(32'h8000_0100, 2'b00, 0, 0, 0, 0, 0, 0, 1);
    check("R7 redirect", {31'd0, gRedir}, 1);
    check("R7 no trapTaken", {31'd0, gTaken}, 0);
    check("R7 nextPc is saved pc", gNpc, 32'h400);
    readCsr(12'h300, v); check("R7 status after return", v, 32'h88);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    timerIrq = 1;
    readCsr(12'h344, v);
    check("R10 timer pending bit", v, 32'h80);
    check("R8 no trap without source enable", {31'd0, gTaken}, 0);
    csrOpReg(2'b01, 12'h344, 32'h0);
    readCsr(12'h344, v);
    check("R10 write ignored", v, 32'h80);
    softIrq = 1;
    readCsr(12'h344, v);
    check("R10 both pending bits", v, 32'h88);
    softIrq = 0;
  endtask

  task automatic t_timerIrq();
    logic [31:0] v;
    csrOpReg(2'b10, 12'h304, 32'h80);
    check("R12 enable write boundary not trapped", {31'd0, gTaken}, 0);
    boundary(32'h0000_0500, 2'b01, 0, 12'h340, 32'h0000_FFFF, 0, 0, 0, 0);
    check("R12 interrupt at next boundary", {31'd0, gTaken}, 1);
    check("R8 nextPc is vector", gNpc, 32'h8000_0100);
    readCsr(12'h342, v); check("R8 timer cause", v, 32'h8000_0007);
    check("R8 no trap with global enable clear", {31'd0, gTaken}, 0);
    readCsr(12'h341, v); check("R8 saved pc", v, 32'h500);
    readCsr(12'h343, v); check("R8 trap value zero", v, 0);
    readCsr(12'h300, v); check("R6 status after interrupt", v, 32'h80);
    readCsr(12'h340, v); check("R12 pre-empted write suppressed", v, 32'h5);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    csrOpImm(2'b10, 12'h304, 5'd8);
    softIrq = 1;
    boundary(32'h8000_0100, 2'b00, 0, 0, 0, 0, 0, 0, 1);
    check("R7 return with enables off", gNpc, 32'h500);
    boundary(32'h0000_0500, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    check("R9 trap taken", {31'd0, gTaken}, 1);
    readCsr(12'h342, v); check("R9 software first", v, 32'h8000_0003);
    timerIrq = 0; softIrq = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle();
    timerIrq = 0; softIrq = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_swap();
    t_setClear();
    t_vector();
    t_exception();
    t_return();
    t_pending();
    t_timerIrq();
    t_priority();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule